// File: doc/BRIEF.md
# Multiple Header Log Queue

This block keeps the error header log for an advanced error reporting capability. It holds a first-error pointer, a 128-bit header log and a 128-bit TLP prefix log, and it advertises the capability bits that go with them. An error detector posts a log request with a one-hot uncorrectable status bit, the header and prefix dwords, and their valid flags. Software clears status bits elsewhere. Each such write is signalled to this block together with the status value that results from it.

When multiple-header recording is enabled and the error that owns the current log is still pending, a new request goes into a circular queue instead of overwriting the log. When software clears the pending bit of the first error, the oldest queued error moves into the log in one cycle. At the same time the block asks the status register to set again the bits of every queued error, so that each logged error stays visible until its header has been read. Configuration-space decoding and the status register itself are outside the block.

Top module: `hdrLogQueue`

## Requirements
- R1: After reset, fep, hdrLog, prefixLog, tlpPrefixLogged, logOverflow, setStatusValid and setStatusMask are all zero.
- R2: ecrcGenCapable and ecrcChkCapable are always 1. mhrCapable is 1 exactly when QDEPTH is non-zero, and mhrEnable has an effect only in that case.
- R3: A log request is loaded into the log when recording is disabled or when uncorStatus[fep] is 0. In that case fep becomes the bit index of the one-hot logStatus (bit 0 gives 0) on the clock edge that samples the request.
- R4: On a load, each header dword k (logHdr[32k+31:32k]) is stored byte-reversed, so input byte 0 becomes log byte 3. If logHdrValid is 0, hdrLog is loaded with zero.
- R5: On a load, the prefix dwords are stored byte-reversed and tlpPrefixLogged is set only when logPrefixPresent and prefixSupported are both 1. Otherwise prefixLog is zero and tlpPrefixLogged is 0.
- R6: With recording enabled and uncorStatus[fep] equal to 1, a log request is queued and fep and both logs are left unchanged.
- R7: A request that would be queued while QDEPTH entries are already waiting is dropped. logOverflow is then 1 for the single cycle after the request edge.
- R8: A status write that leaves uncorStatus[fep] at 0, while recording is disabled or the queue is empty, clears fep, hdrLog, prefixLog and tlpPrefixLogged.
- R9: A status write that leaves uncorStatus[fep] at 0, while recording is enabled and the queue holds entries, loads the oldest queued entry (first in, first out) by the rules of R4 and R5. For one cycle it also raises setStatusValid with setStatusMask equal to the one-hot bits of all entries that were queued, the popped one included.
- R10: A status write that leaves uncorStatus[fep] at 1, with recording enabled and the queue not empty, raises setStatusValid for one cycle with the mask of all queued entries, and the log is left unchanged.
- R11: A status write that leaves uncorStatus[fep] at 1 while recording is disabled empties the queue, and the log is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mhrEnable | input | 1 | Multiple-header recording enable from the control register |
| prefixSupported | input | 1 | End-to-end TLP prefix support is advertised |
| logReq | input | 1 | Log request strobe |
| logStatus | input | 32 | One-hot uncorrectable status bit of the request |
| logHdrValid | input | 1 | Header dwords of the request are valid |
| logHdr | input | 128 | Four header dwords, dword 0 in the low bits |
| logPrefixPresent | input | 1 | Request carries a TLP prefix (requires logHdrValid) |
| logPrefix | input | 128 | Four prefix dwords, dword 0 in the low bits |
| statusWrite | input | 1 | Software has just written the uncorrectable status register |
| uncorStatus | input | 32 | Current uncorrectable status register value |
| fep | output | 5 | First-error pointer |
| hdrLog | output | 128 | Header log contents |
| prefixLog | output | 128 | TLP prefix log contents |
| tlpPrefixLogged | output | 1 | Prefix log holds valid data |
| mhrCapable | output | 1 | Multiple-header recording capable |
| ecrcGenCapable | output | 1 | ECRC generation capable |
| ecrcChkCapable | output | 1 | ECRC check capable |
| logOverflow | output | 1 | Request was dropped because the queue is full |
| setStatusValid | output | 1 | Request to OR setStatusMask into the status register |
| setStatusMask | output | 32 | Status bits of queued errors to set again |

## Verification
A head pointer, count or slot-valid bit that goes wrong shows up at the ports only on a later event. It appears as a wrong setStatusMask on the next status write, as the wrong header popped into hdrLog after a first-error clear, or as logOverflow arriving too early or too late. This can be many cycles after the fault. For that reason every request and every status write is compared, one cycle after its edge, against a model of the queue kept in the bench, and the random phase runs long enough to fill, drain, flush and overflow the queue many times. A wrong pointer after a clear shows at once, because the next request is then queued or loaded against the wrong decision.

// File: rtl/hdrLogPkg.sv
package hdrLogPkg;
  localparam int STATUS_W   = 32;
  localparam int IDX_W      = $clog2(STATUS_W);
  localparam int DWORD_W    = 32;
  localparam int DW_BYTES   = DWORD_W / 8;
  localparam int LOG_DWORDS = 4;
  localparam int LOG_W      = DWORD_W * LOG_DWORDS;

  // one pending error as captured from the requester
  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             hdrValid;
    logic [LOG_W-1:0] hdr;
    logic             prefixPresent;
    logic [LOG_W-1:0] prefix;
  } logEntry_t;

  // strobes from control to datapath, at most one action family per cycle
  typedef struct packed {
    logic loadNew;
    logic loadHead;
    logic clearLog;
    logic push;
    logic pop;
    logic flush;
    logic overflow;
    logic restore;
  } logCtrl_t;

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [STATUS_W-1:0] s);
    lowestIdx = '0;
    for (int i = STATUS_W - 1; i >= 0; i--) begin
      if (s[i]) lowestIdx = IDX_W'(i);
    end
  endfunction

  function automatic logic [LOG_W-1:0] byteSwapLog(input logic [LOG_W-1:0] d);
    byteSwapLog = '0;
    for (int k = 0; k < LOG_DWORDS; k++) begin
      for (int b = 0; b < DW_BYTES; b++) begin
        byteSwapLog[k*DWORD_W + b*8 +: 8] = d[k*DWORD_W + (DW_BYTES-1-b)*8 +: 8];
      end
    end
  endfunction
endpackage

// File: rtl/hdrLogCtrl.sv
module hdrLogCtrl
  import hdrLogPkg::*;
(
  input  logic                logReq,
  input  logic                statusWrite,
  input  logic [STATUS_W-1:0] uncorStatus,
  input  logic [IDX_W-1:0]    fep,
  input  logic                mhrEn,
  input  logic                qEmpty,
  input  logic                qFull,
  output logCtrl_t            ctrl
);
  logic firstSet;
  assign firstSet = uncorStatus[fep];

  always_comb begin
    ctrl = '0;
    if (statusWrite) begin
      if (!firstSet) begin
        if (!mhrEn || qEmpty) begin
          ctrl.clearLog = 1'b1;
        end else begin
          ctrl.restore  = 1'b1;
          ctrl.pop      = 1'b1;
          ctrl.loadHead = 1'b1;
        end
      end else if (mhrEn) begin
        ctrl.restore = !qEmpty;
      end else begin
        ctrl.flush = 1'b1;
      end
    end else if (logReq) begin
      if (mhrEn && firstSet) begin
        if (qFull) ctrl.overflow = 1'b1;
        else       ctrl.push     = 1'b1;
      end else begin
        ctrl.loadNew = 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdrLogFifo.sv
module hdrLogFifo
  import hdrLogPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                push,
  input  logic                pop,
  input  logic                flush,
  input  logEntry_t           pushEntry,
  output logEntry_t           headEntry,
  output logic                empty,
  output logic                full,
  output logic [STATUS_W-1:0] pendingMask
);
  localparam int SLOTS = (DEPTH > 0) ? DEPTH : 1;
  localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W = $clog2(SLOTS + 1);

  logEntry_t        mem [SLOTS];
  logic [SLOTS-1:0] slotValid;
  logic [PTR_W-1:0] head, tail, headNext;
  logic [CNT_W-1:0] count;

  always_comb begin
    int sum;
    sum = int'(head) + int'(count);
    if (sum >= SLOTS) sum = sum - SLOTS;
    tail     = PTR_W'(sum);
    headNext = (head == PTR_W'(SLOTS - 1)) ? '0 : head + 1'b1;
  end

  assign empty     = (count == '0);
  assign full      = (count == CNT_W'(DEPTH));
  assign headEntry = mem[head];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      head      <= '0;
      count     <= '0;
      slotValid <= '0;
    end else if (flush) begin
      count     <= '0;
      slotValid <= '0;
    end else if (push) begin
      slotValid[tail] <= 1'b1;
      count           <= count + 1'b1;
    end else if (pop) begin
      slotValid[head] <= 1'b0;
      head            <= headNext;
      count           <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[tail] <= pushEntry;
  end

  always_comb begin
    pendingMask = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (slotValid[i]) pendingMask[mem[i].idx] = 1'b1;
    end
  end
endmodule

// File: rtl/hdrLogData.sv
module hdrLogData
  import hdrLogPkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logCtrl_t            ctrl,
  input  logEntry_t           newEntry,
  input  logic                prefixSupported,
  output logic                qEmpty,
  output logic                qFull,
  output logic [IDX_W-1:0]    fep,
  output logic [LOG_W-1:0]    hdrLog,
  output logic [LOG_W-1:0]    prefixLog,
  output logic                tlpPrefixLogged,
  output logic                logOverflow,
  output logic                setStatusValid,
  output logic [STATUS_W-1:0] setStatusMask
);
  logEntry_t           headEntry, srcEntry;
  logic [STATUS_W-1:0] pendingMask;
  logic                usePrefix;

  hdrLogFifo #(.DEPTH(QDEPTH)) uFifo (
    .clk        (clk),
    .rstN       (rstN),
    .push       (ctrl.push),
    .pop        (ctrl.pop),
    .flush      (ctrl.flush),
    .pushEntry  (newEntry),
    .headEntry  (headEntry),
    .empty      (qEmpty),
    .full       (qFull),
    .pendingMask(pendingMask)
  );

  assign srcEntry  = ctrl.loadHead ? headEntry : newEntry;
  assign usePrefix = srcEntry.prefixPresent && prefixSupported;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fep             <= '0;
      hdrLog          <= '0;
      prefixLog       <= '0;
      tlpPrefixLogged <= 1'b0;
      logOverflow     <= 1'b0;
      setStatusValid  <= 1'b0;
      setStatusMask   <= '0;
    end else begin
      logOverflow    <= ctrl.overflow;
      setStatusValid <= ctrl.restore;
      setStatusMask  <= ctrl.restore ? pendingMask : '0;
      if (ctrl.clearLog) begin
        fep             <= '0;
        hdrLog          <= '0;
        prefixLog       <= '0;
        tlpPrefixLogged <= 1'b0;
      end else if (ctrl.loadNew || ctrl.loadHead) begin
        fep             <= srcEntry.idx;
        hdrLog          <= srcEntry.hdrValid ? byteSwapLog(srcEntry.hdr) : '0;
        prefixLog       <= usePrefix ? byteSwapLog(srcEntry.prefix) : '0;
        tlpPrefixLogged <= usePrefix;
      end
    end
  end
endmodule

// File: rtl/hdrLogQueue.sv
module hdrLogQueue
  import hdrLogPkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                mhrEnable,
  input  logic                prefixSupported,
  input  logic                logReq,
  input  logic [STATUS_W-1:0] logStatus,
  input  logic                logHdrValid,
  input  logic [LOG_W-1:0]    logHdr,
  input  logic                logPrefixPresent,
  input  logic [LOG_W-1:0]    logPrefix,
  input  logic                statusWrite,
  input  logic [STATUS_W-1:0] uncorStatus,
  output logic [IDX_W-1:0]    fep,
  output logic [LOG_W-1:0]    hdrLog,
  output logic [LOG_W-1:0]    prefixLog,
  output logic                tlpPrefixLogged,
  output logic                mhrCapable,
  output logic                ecrcGenCapable,
  output logic                ecrcChkCapable,
  output logic                logOverflow,
  output logic                setStatusValid,
  output logic [STATUS_W-1:0] setStatusMask
);
  logCtrl_t  ctrl;
  logEntry_t newEntry;
  logic      mhrEn, qEmpty, qFull;

  generate
    if (QDEPTH > 0) begin : gQueue
      assign mhrCapable = 1'b1;
      assign mhrEn      = mhrEnable;
    end else begin : gNoQueue
      assign mhrCapable = 1'b0;
      assign mhrEn      = 1'b0;
    end
  endgenerate

  assign ecrcGenCapable = 1'b1;
  assign ecrcChkCapable = 1'b1;

  assign newEntry.idx           = lowestIdx(logStatus);
  assign newEntry.hdrValid      = logHdrValid;
  assign newEntry.hdr           = logHdr;
  assign newEntry.prefixPresent = logPrefixPresent;
  assign newEntry.prefix        = logPrefix;

  hdrLogCtrl uCtrl (
    .logReq     (logReq),
    .statusWrite(statusWrite),
    .uncorStatus(uncorStatus),
    .fep        (fep),
    .mhrEn      (mhrEn),
    .qEmpty     (qEmpty),
    .qFull      (qFull),
    .ctrl       (ctrl)
  );

  hdrLogData #(.QDEPTH(QDEPTH)) uData (
    .clk            (clk),
    .rstN           (rstN),
    .ctrl           (ctrl),
    .newEntry       (newEntry),
    .prefixSupported(prefixSupported),
    .qEmpty         (qEmpty),
    .qFull          (qFull),
    .fep            (fep),
    .hdrLog         (hdrLog),
    .prefixLog      (prefixLog),
    .tlpPrefixLogged(tlpPrefixLogged),
    .logOverflow    (logOverflow),
    .setStatusValid (setStatusValid),
    .setStatusMask  (setStatusMask)
  );
endmodule

// File: rtl/hdrLogQueueChk.sv
module hdrLogQueueChk
  import hdrLogPkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                mhrEnable,
  input logic                mhrCapable,
  input logic                prefixSupported,
  input logic                logReq,
  input logic [STATUS_W-1:0] logStatus,
  input logic                logHdrValid,
  input logic                logPrefixPresent,
  input logic                statusWrite,
  input logic [STATUS_W-1:0] uncorStatus,
  input logic [IDX_W-1:0]    fep,
  input logic [LOG_W-1:0]    hdrLog,
  input logic [LOG_W-1:0]    prefixLog,
  input logic                tlpPrefixLogged,
  input logic                logOverflow,
  input logic                setStatusValid
);
  // R3
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    logReq |-> ($countones(logStatus) == 1));

  // R5
  prefix_needs_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (logReq && !logHdrValid) |-> !logPrefixPresent);

  // R9
  req_write_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(logReq && statusWrite));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    logOverflow |-> $past(logReq));

  // R10
  restore_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    setStatusValid |-> $past(statusWrite));

  // R8
  clear_log_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrite && !uncorStatus[fep] && !(mhrEnable && mhrCapable))
      |=> (fep == '0 && hdrLog == '0 && prefixLog == '0 && !tlpPrefixLogged));

  // R5
  prefix_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tlpPrefixLogged) |-> $past(prefixSupported));

  // R6
  fep_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(fep) |-> $past(logReq || statusWrite));
endmodule

bind hdrLogQueue hdrLogQueueChk u_chk (
  .clk             (clk),
  .rstN            (rstN),
  .mhrEnable       (mhrEnable),
  .mhrCapable      (mhrCapable),
  .prefixSupported (prefixSupported),
  .logReq          (logReq),
  .logStatus       (logStatus),
  .logHdrValid     (logHdrValid),
  .logPrefixPresent(logPrefixPresent),
  .statusWrite     (statusWrite),
  .uncorStatus     (uncorStatus),
  .fep             (fep),
  .hdrLog          (hdrLog),
  .prefixLog       (prefixLog),
  .tlpPrefixLogged (tlpPrefixLogged),
  .logOverflow     (logOverflow),
  .setStatusValid  (setStatusValid)
);

// File: tb/sim_hdrLogQueue.sv
module sim_hdrLogQueue;
  localparam int CLK_PERIOD = 10;
  localparam int QD = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         mhrEnable = 1'b0, prefixSupported = 1'b1;
  logic         logReq = 1'b0, logHdrValid = 1'b0, logPrefixPresent = 1'b0;
  logic [31:0]  logStatus = '0;
  logic [127:0] logHdr = '0, logPrefix = '0;
  logic         statusWrite = 1'b0;
  logic [31:0]  uncorStatus = '0;
  logic [4:0]   fep;
  logic [127:0] hdrLog, prefixLog;
  logic         tlpPrefixLogged, mhrCapable, ecrcGenCapable, ecrcChkCapable;
  logic         logOverflow, setStatusValid;
  logic [31:0]  setStatusMask;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdrLogQueue #(.QDEPTH(QD)) u0 (.*);

  int tests = 0, fails = 0;

  // bench model
  logic [31:0]  statusReg = '0;
  logic [4:0]   mFep = '0;
  logic [127:0] mHdr = '0, mPre = '0;
  logic         mTlp = 1'b0;
  logic [4:0]   qIdx [QD];
  logic         qHv [QD], qPp [QD];
  logic [127:0] qHdr [QD], qPre [QD];
  int           qHead = 0, qCnt = 0;

  function automatic logic [127:0] swapDw(input logic [127:0] d);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] w;
      w = d[32*k +: 32];
      r[32*k +: 32] = {w[7:0], w[15:8], w[23:16], w[31:24]};
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkLog(input string req);
    chk(fep == mFep, req, "fep", 128'(fep), 128'(mFep));
    chk(hdrLog == mHdr, req, "hdrLog", hdrLog, mHdr);
    chk(prefixLog == mPre, req, "prefixLog", prefixLog, mPre);
    chk(tlpPrefixLogged == mTlp, req, "tlpPrefixLogged", 128'(tlpPrefixLogged), 128'(mTlp));
  endtask

  task automatic modelLoad(input logic [4:0] idx, input logic hv, input logic [127:0] h,
                           input logic pp, input logic [127:0] p);
    mFep = idx;
    mHdr = hv ? swapDw(h) : '0;
    mTlp = pp && prefixSupported;
    mPre = mTlp ? swapDw(p) : '0;
  endtask

  task automatic doLog(input int idx, input logic hv, input logic [127:0] h,
                       input logic pp, input logic [127:0] p, input string req);
    logic expOv;
    @(negedge clk);
    logReq = 1'b1; logStatus = 32'd1 << idx; logHdrValid = hv; logHdr = h;
    logPrefixPresent = pp; logPrefix = p; uncorStatus = statusReg;
    expOv = 1'b0;
    if (mhrEnable && statusReg[mFep]) begin
      if (qCnt == QD) expOv = 1'b1;
      else begin
        int t;
        t = (qHead + qCnt) % QD;
        qIdx[t] = 5'(idx); qHv[t] = hv; qHdr[t] = h; qPp[t] = pp; qPre[t] = p;
        qCnt++;
      end
    end else modelLoad(5'(idx), hv, h, pp, p);
    @(negedge clk);
    logReq = 1'b0;
    checkLog(req);
    chk(logOverflow == expOv, req, "logOverflow", 128'(logOverflow), 128'(expOv));
    chk(!setStatusValid, req, "setStatusValid", 128'(setStatusValid), 128'(0));
    statusReg[idx] = 1'b1;
  endtask

  task automatic doWrite(input logic [31:0] clr, input string req);
    logic        expV;
    logic [31:0] expM, orQ;
    @(negedge clk);
    statusReg = statusReg & ~clr;
    uncorStatus = statusReg; statusWrite = 1'b1;
    orQ = '0;
    for (int i = 0; i < qCnt; i++) orQ[qIdx[(qHead + i) % QD]] = 1'b1;
    expV = 1'b0; expM = '0;
    if (!statusReg[mFep]) begin
      if (!mhrEnable || qCnt == 0) begin
        mFep = '0; mHdr = '0; mPre = '0; mTlp = 1'b0;
      end else begin
        expV = 1'b1; expM = orQ;
        modelLoad(qIdx[qHead], qHv[qHead], qHdr[qHead], qPp[qHead], qPre[qHead]);
        qHead = (qHead + 1) % QD; qCnt--;
      end
    end else if (mhrEnable) begin
      if (qCnt > 0) begin expV = 1'b1; expM = orQ; end
    end else qCnt = 0;
    @(negedge clk);
    statusWrite = 1'b0;
    checkLog(req);
    chk(setStatusValid == expV, req, "setStatusValid", 128'(setStatusValid), 128'(expV));
    chk(setStatusMask == expM, req, "setStatusMask", 128'(setStatusMask), 128'(expM));
    chk(!logOverflow, req, "logOverflow", 128'(logOverflow), 128'(0));
    if (expV) statusReg = statusReg | expM;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkLog("R1");
    chk(!logOverflow && !setStatusValid && setStatusMask == 0, "R1", "pulses",
        128'({logOverflow, setStatusValid}), 128'(0));
    // R2 capability bits
    chk(ecrcGenCapable && ecrcChkCapable, "R2", "ecrc caps",
        128'({ecrcGenCapable, ecrcChkCapable}), 128'(3));
    chk(mhrCapable == 1'b1, "R2", "mhrCapable", 128'(mhrCapable), 128'(1));

    // direct loads, recording disabled
    doLog(5, 1'b1, 128'h0f0e0d0c_0b0a0908_07060504_03020100, 1'b1,
          128'h11223344_55667788_99aabbcc_ddeeff00, "R3");
    doLog(9, 1'b1, rnd128(), 1'b0, rnd128(), "R3");
    doLog(0, 1'b0, rnd128(), 1'b0, rnd128(), "R4");
    prefixSupported = 1'b0;
    doLog(17, 1'b1, rnd128(), 1'b1, rnd128(), "R5");
    prefixSupported = 1'b1;
    doWrite(32'hffff_ffff, "R8");

    // queueing, overflow, restore, pop order
    mhrEnable = 1'b1;
    doLog(3, 1'b1, rnd128(), 1'b1, rnd128(), "R3");
    doLog(7, 1'b1, rnd128(), 1'b1, rnd128(), "R6");
    doLog(1, 1'b0, rnd128(), 1'b0, rnd128(), "R6");
    doLog(12, 1'b1, rnd128(), 1'b0, rnd128(), "R6");
    doLog(20, 1'b1, rnd128(), 1'b1, rnd128(), "R6");
    doLog(30, 1'b1, rnd128(), 1'b1, rnd128(), "R7");
    doWrite(32'd1 << 7, "R10");
    doWrite(32'd1 << 3, "R9");
    doWrite(32'd1 << 7, "R9");
    doWrite(32'd1 << 1, "R9");
    doWrite(32'd1 << 12, "R9");
    doWrite(32'd1 << 20, "R8");

    // flush with recording disabled
    doLog(4, 1'b1, rnd128(), 1'b0, rnd128(), "R3");
    doLog(6, 1'b1, rnd128(), 1'b0, rnd128(), "R6");
    doLog(8, 1'b1, rnd128(), 1'b0, rnd128(), "R6");
    mhrEnable = 1'b0;
    doWrite(32'd0, "R11");
    mhrEnable = 1'b1;
    doWrite(32'hffff_ffff, "R11");

    // random phase
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom % 20;
      if (r == 0) mhrEnable = ~mhrEnable;
      else if (r == 1) prefixSupported = ~prefixSupported;
      else if (r < 12) begin
        logic hv;
        hv = 1'($urandom);
        doLog($urandom % 32, hv, rnd128(), hv & 1'($urandom), rnd128(), "R6");
      end else if (r < 16) doWrite(32'd1 << mFep, "R9");
      else doWrite($urandom & $urandom & $urandom, "R10");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule